// File: doc/BRIEF.md
# Keyed Domain Reset Request Controller

This block lives in an always-on domain and decides when a subordinate power domain is to be reset. Software controls it through a single 32-bit control word on a plain write-strobe bus, and it can read the word back at any time. A reset happens only when software writes an exact 4-bit key (4'b0110) into one of two key fields. One field asks for a warm reset and the other asks for a cold (power-on) reset. Two hardware sources can also ask for a cold reset: an error-event line and a security-manager request line. Each has its own active-low enable bit in the control word.

The CPUs of the controlled domain can defer a warm reset by setting a block bit. If a warm request arrives while that bit is set, the request is latched and an interrupt tells those CPUs that a reset is waiting. The reset goes ahead once they clear the bit. A cold request is never deferred, and it takes over any pending warm request. Both outputs are one-cycle request pulses to an external sequencer. The control word belongs to the controlled domain, so every issued reset returns all of its fields to their defaults. The key fields then read 4'hF and must be written again before another reset can happen.

The controller is a four-state machine:
- ST_IDLE: nothing is pending.
- ST_WARM_PEND: a warm request is latched and waits for the block bit to clear.
- ST_WARM_FIRE: the warm pulse is driven.
- ST_COLD_FIRE: the cold pulse is driven.

Its transitions:
- IDLE→COLD_FIRE and WARM_PEND→COLD_FIRE happen on any enabled cold source.
- IDLE→WARM_PEND happens on a warm key write.
- WARM_PEND→WARM_FIRE happens when the block bit reads 0.
- WARM_FIRE→IDLE and COLD_FIRE→IDLE happen unconditionally.

Top module: `dom_rst_ctrl`

## Requirements
- R1: After the always-on reset, the control word reads 32'h0002_00FF, and the warm, cold and interrupt outputs are all low.
- R2: A write with bits 3:0 equal to 4'b0110 and bits 7:4 not equal to the key, made while bit 18 is 0, gives exactly one `warm_rst_req` pulse. The pulse is in the second cycle after the write edge.
- R3: A write with bits 7:4 equal to 4'b0110 gives one `cold_rst_req` pulse in the cycle right after the write edge.
- R4: A write whose key fields are not 4'b0110 requests no reset. The fields store the values written and read them back.
- R5: Bits 31:19 and 15:8 always read 0 and ignore the data written to them.
- R6: In the cycle after any warm or cold pulse, the control word reads 32'h0002_00FF again.
- R7: A warm request made while bit 18 is 1 stays pending with no warm pulse, and `pend_irq` is high. After a write clears bit 18, `pend_irq` is low in the cycle after that write edge, and the warm pulse comes one cycle later.
- R8: A cold request is not held back by bit 18. A cold request that arrives while a warm request is pending gives a cold pulse, drops `pend_irq`, and cancels the warm request.
- R9: A single write that puts the key in both bits 3:0 and bits 7:4 gives only a cold pulse.
- R10: When bit 17 is 0, a high `err_evt` gives a cold pulse in the next cycle. When bit 17 is 1, `err_evt` is ignored.
- R11: When bit 16 is 0, a high `sec_rst_req` gives a cold pulse in the next cycle. When bit 16 is 1, it is ignored and the control word keeps its value.
- R12: `warm_rst_req` and `cold_rst_req` are never high together, and each one lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Always-on active-low reset |
| bus_wr | input | 1 | Write strobe for the control word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Current control word |
| err_evt | input | 1 | Error-event cold reset request |
| sec_rst_req | input | 1 | Security-manager cold reset request |
| warm_rst_req | output | 1 | One-cycle warm reset pulse to the sequencer |
| cold_rst_req | output | 1 | One-cycle cold reset pulse to the sequencer |
| pend_irq | output | 1 | Warm reset pending while blocked |

## Verification
Key writes are tried in several forms:
- the key alone in the warm field;
- the key alone in the cold field;
- the key in both fields at once;
- non-key codes such as 4'h5, 4'h7, 4'h0 and 4'hE.

Together these separate an exact key match from a partial or nonzero match, and they show the cold-over-warm priority. A separate set of writes fills the reserved bits with ones, to show they are dropped. The blocking handshake is run twice: once released by clearing the block bit, and once pre-empted by a cold key. Each hardware source is driven with its enable bit both asserted and deasserted, which tells the active-low polarity apart from a plain enable.

// File: rtl/dom_rst_pkg.sv
package dom_rst_pkg;

    localparam int DATA_W   = 32;
    localparam int KEY_W    = 4;

    localparam int WKEY_LSB = 0;
    localparam int PKEY_LSB = 4;
    localparam int SEC_BIT  = 16;
    localparam int ERR_BIT  = 17;
    localparam int BLK_BIT  = 18;

    localparam logic [KEY_W-1:0] KEY_IDLE = '1;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WARM_PEND = 2'd1,
        ST_WARM_FIRE = 2'd2,
        ST_COLD_FIRE = 2'd3
    } rst_state_e;

    typedef struct packed {
        logic             blk;
        logic             err_off;
        logic             sec_off;
        logic [KEY_W-1:0] por_key;
        logic [KEY_W-1:0] warm_key;
    } ctl_fields_t;

    localparam ctl_fields_t FIELD_DEFAULTS = '{
        blk:      1'b0,
        err_off:  1'b1,
        sec_off:  1'b0,
        por_key:  KEY_IDLE,
        warm_key: KEY_IDLE
    };

endpackage

// File: rtl/dom_rst_regs.sv
module dom_rst_regs
    import dom_rst_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              restore,
    input  ctl_fields_t       wr_fields,
    output ctl_fields_t       fields,
    output logic [DATA_W-1:0] rdata
);

    // Field storage: always-on reset, then restore on any issued domain reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fields <= FIELD_DEFAULTS;
        end else if (restore) begin
            fields <= FIELD_DEFAULTS;
        end else if (wr_en) begin
            fields <= wr_fields;
        end
    end

    // Read image; reserved positions stay zero
    always_comb begin
        rdata                             = '0;
        rdata[WKEY_LSB +: KEY_W]          = fields.warm_key;
        rdata[PKEY_LSB +: KEY_W]          = fields.por_key;
        rdata[SEC_BIT]                    = fields.sec_off;
        rdata[ERR_BIT]                    = fields.err_off;
        rdata[BLK_BIT]                    = fields.blk;
    end

endmodule

// File: rtl/dom_rst_trig.sv
module dom_rst_trig
    import dom_rst_pkg::*;
#(
    parameter logic [KEY_W-1:0] FIRE_KEY = 4'b0110
) (
    input  logic             wr_en,
    input  logic [KEY_W-1:0] wr_warm_key,
    input  logic [KEY_W-1:0] wr_por_key,
    input  logic             err_evt,
    input  logic             sec_req,
    input  logic             err_off,
    input  logic             sec_off,
    output logic             warm_key_hit,
    output logic             cold_req
);

    logic por_key_hit;
    logic err_hit;
    logic sec_hit;

    always_comb begin
        warm_key_hit = wr_en && (wr_warm_key == FIRE_KEY);
        por_key_hit  = wr_en && (wr_por_key == FIRE_KEY);
        err_hit      = err_evt && !err_off;
        sec_hit      = sec_req && !sec_off;
        cold_req     = por_key_hit || err_hit || sec_hit;
    end

endmodule

// File: rtl/dom_rst_fsm.sv
module dom_rst_fsm
    import dom_rst_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cold_req,
    input  logic       warm_key_hit,
    input  logic       blk,
    output logic       warm_fire,
    output logic       cold_fire,
    output logic       pend_irq
);

    rst_state_e state_q;
    rst_state_e state_nx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // Transitions
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cold_req) begin
                    state_nx = ST_COLD_FIRE;
                end else if (warm_key_hit) begin
                    state_nx = ST_WARM_PEND;
                end
            end
            ST_WARM_PEND: begin
                if (cold_req) begin
                    state_nx = ST_COLD_FIRE;
                end else if (!blk) begin
                    state_nx = ST_WARM_FIRE;
                end
            end
            ST_WARM_FIRE: state_nx = ST_IDLE;
            ST_COLD_FIRE: state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // Outputs (Moore)
    always_comb begin
        warm_fire = 1'b0;
        cold_fire = 1'b0;
        pend_irq  = 1'b0;
        unique case (state_q)
            ST_IDLE:      ;
            ST_WARM_PEND: pend_irq  = blk;
            ST_WARM_FIRE: warm_fire = 1'b1;
            ST_COLD_FIRE: cold_fire = 1'b1;
            default:      ;
        endcase
    end

endmodule

// File: rtl/dom_rst_ctrl.sv
module dom_rst_ctrl
    import dom_rst_pkg::*;
#(
    parameter logic [KEY_W-1:0] FIRE_KEY = 4'b0110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              err_evt,
    input  logic              sec_rst_req,
    output logic              warm_rst_req,
    output logic              cold_rst_req,
    output logic              pend_irq
);

    ctl_fields_t wr_fields;
    ctl_fields_t fields;
    logic        warm_key_hit;
    logic        cold_req;
    logic        restore;

    always_comb begin
        wr_fields.warm_key = bus_wdata[WKEY_LSB +: KEY_W];
        wr_fields.por_key  = bus_wdata[PKEY_LSB +: KEY_W];
        wr_fields.sec_off  = bus_wdata[SEC_BIT];
        wr_fields.err_off  = bus_wdata[ERR_BIT];
        wr_fields.blk      = bus_wdata[BLK_BIT];
        restore            = warm_rst_req || cold_rst_req;
    end

    dom_rst_regs i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr),
        .restore   (restore),
        .wr_fields (wr_fields),
        .fields    (fields),
        .rdata     (bus_rdata)
    );

    dom_rst_trig #(
        .FIRE_KEY (FIRE_KEY)
    ) i_trig (
        .wr_en        (bus_wr),
        .wr_warm_key  (wr_fields.warm_key),
        .wr_por_key   (wr_fields.por_key),
        .err_evt      (err_evt),
        .sec_req      (sec_rst_req),
        .err_off      (fields.err_off),
        .sec_off      (fields.sec_off),
        .warm_key_hit (warm_key_hit),
        .cold_req     (cold_req)
    );

    dom_rst_fsm i_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cold_req     (cold_req),
        .warm_key_hit (warm_key_hit),
        .blk          (fields.blk),
        .warm_fire    (warm_rst_req),
        .cold_fire    (cold_rst_req),
        .pend_irq     (pend_irq)
    );

endmodule

// File: rtl/dom_rst_chk.sv
module dom_rst_chk
    import dom_rst_pkg::*;
#(
    parameter logic [KEY_W-1:0] FIRE_KEY = 4'b0110
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [KEY_W-1:0]  wr_por_key,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              err_evt,
    input logic              warm_rst_req,
    input logic              cold_rst_req,
    input logic              pend_irq
);

    localparam logic [DATA_W-1:0] RD_DEFAULT = 32'h0002_00FF;

    AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(warm_rst_req && cold_rst_req)); // R12
    AST_WARM_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) warm_rst_req |=> !warm_rst_req); // R12
    AST_COLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) cold_rst_req |=> !cold_rst_req); // R12
    AST_IRQ_NEEDS_BLOCK: assert property (@(posedge clk) disable iff (!rst_n) pend_irq |-> bus_rdata[BLK_BIT]); // R7
    AST_WARM_AFTER_UNBLOCK: assert property (@(posedge clk) disable iff (!rst_n) $rose(warm_rst_req) |-> !$past(bus_rdata[BLK_BIT])); // R7
    AST_RESTORE_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n) (warm_rst_req || cold_rst_req) |=> (bus_rdata == RD_DEFAULT)); // R6
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (bus_rdata[31:19] == '0) && (bus_rdata[15:8] == '0)); // R5
    AST_COLD_ON_KEY: assert property (@(posedge clk) disable iff (!rst_n) (bus_wr && (wr_por_key == FIRE_KEY) && !warm_rst_req && !cold_rst_req) |=> cold_rst_req); // R3
    AST_ERR_COLD: assert property (@(posedge clk) disable iff (!rst_n) (err_evt && !bus_rdata[ERR_BIT] && !warm_rst_req && !cold_rst_req) |=> cold_rst_req); // R10

endmodule

bind dom_rst_ctrl dom_rst_chk #(.FIRE_KEY(FIRE_KEY)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .wr_por_key   (bus_wdata[7:4]),
    .bus_rdata    (bus_rdata),
    .err_evt      (err_evt),
    .warm_rst_req (warm_rst_req),
    .cold_rst_req (cold_rst_req),
    .pend_irq     (pend_irq)
);

// File: tb/test_dom_rst_ctrl.sv
module test_dom_rst_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] RD_DEF = 32'h0002_00FF;

    typedef struct packed {
        logic [31:0] wd;
        logic        w1;
        logic        c1;
        logic        w2;
        logic [31:0] rd;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{32'h0002_00F6, 1'b0, 1'b0, 1'b1, RD_DEF},        // R2 warm key
        '{32'h0002_006F, 1'b0, 1'b1, 1'b0, RD_DEF},        // R3 cold key
        '{32'h0002_0066, 1'b0, 1'b1, 1'b0, RD_DEF},        // R9 both keys
        '{32'h0002_00F5, 1'b0, 1'b0, 1'b0, 32'h0002_00F5}, // R4 near key
        '{32'h0002_0007, 1'b0, 1'b0, 1'b0, 32'h0002_0007}, // R4
        '{32'hFFF8_FF39, 1'b0, 1'b0, 1'b0, 32'h0000_0039}, // R5 reserved ones
        '{32'h0003_00E6, 1'b0, 1'b0, 1'b1, RD_DEF},        // R2 with cold field E
        '{32'h0001_0A0F, 1'b0, 1'b0, 1'b0, 32'h0001_000F}  // R4 R5
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        err_evt = 1'b0;
    logic        sec_rst_req = 1'b0;
    logic        warm_rst_req;
    logic        cold_rst_req;
    logic        pend_irq;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dom_rst_ctrl i_dom_rst_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_wr       (bus_wr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .err_evt      (err_evt),
        .sec_rst_req  (sec_rst_req),
        .warm_rst_req (warm_rst_req),
        .cold_rst_req (cold_rst_req),
        .pend_irq     (pend_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Ends at the falling edge after the write edge
    task automatic write_word(input logic [31:0] d);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_wdata = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rdata", bus_rdata, RD_DEF);
        check("R1 outputs", {29'd0, warm_rst_req, cold_rst_req, pend_irq}, 32'd0);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            write_word(VECS[i].wd);
            check("R2/R3/R9 warm cycle1", {31'd0, warm_rst_req}, {31'd0, VECS[i].w1});
            check("R3/R9 cold cycle1", {31'd0, cold_rst_req}, {31'd0, VECS[i].c1});
            @(negedge clk);
            check("R2/R9/R12 warm cycle2", {31'd0, warm_rst_req}, {31'd0, VECS[i].w2});
            check("R12 cold cycle2", {31'd0, cold_rst_req}, 32'd0);
            @(negedge clk);
            @(negedge clk);
            check("R4/R5/R6 readback", bus_rdata, VECS[i].rd);
        end

        // R7 blocked warm then release
        write_word(32'h0006_00F6);
        check("R7 irq raised", {31'd0, pend_irq}, 32'd1);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check("R7 warm held", {30'd0, warm_rst_req, cold_rst_req}, 32'd0);
        end
        check("R7 irq held", {31'd0, pend_irq}, 32'd1);
        write_word(32'h0002_00FF);
        check("R7 irq dropped", {31'd0, pend_irq}, 32'd0);
        check("R7 no warm yet", {31'd0, warm_rst_req}, 32'd0);
        @(negedge clk);
        check("R7 warm released", {31'd0, warm_rst_req}, 32'd1);
        @(negedge clk);
        check("R6 restore after release", bus_rdata, RD_DEF);

        // R8 cold pre-empts blocked warm
        write_word(32'h0006_00F6);
        check("R8 pending", {31'd0, pend_irq}, 32'd1);
        write_word(32'h0006_006F);
        check("R8 cold not blocked", {31'd0, cold_rst_req}, 32'd1);
        check("R8 irq drops", {31'd0, pend_irq}, 32'd0);
        @(negedge clk);
        check("R8 warm cancelled", {31'd0, warm_rst_req}, 32'd0);
        check("R8 restore", bus_rdata, RD_DEF);
        @(negedge clk);
        check("R8 warm stays cancelled", {30'd0, warm_rst_req, pend_irq}, 32'd0);

        // R10 error source
        @(negedge clk);
        err_evt = 1'b1;
        @(negedge clk);
        check("R10 err ignored when disabled", {31'd0, cold_rst_req}, 32'd0);
        err_evt = 1'b0;
        check("R10 word kept", bus_rdata, RD_DEF);
        write_word(32'h0000_00FF);
        err_evt = 1'b1;
        @(negedge clk);
        check("R10 err causes cold", {31'd0, cold_rst_req}, 32'd1);
        err_evt = 1'b0;
        @(negedge clk);
        check("R10 restore", bus_rdata, RD_DEF);

        // R11 security source
        sec_rst_req = 1'b1;
        @(negedge clk);
        check("R11 sec causes cold", {31'd0, cold_rst_req}, 32'd1);
        sec_rst_req = 1'b0;
        @(negedge clk);
        check("R11 restore", bus_rdata, RD_DEF);
        write_word(32'h0003_00FF);
        sec_rst_req = 1'b1;
        @(negedge clk);
        check("R11 sec ignored when disabled", {31'd0, cold_rst_req}, 32'd0);
        sec_rst_req = 1'b0;
        @(negedge clk);
        check("R11 word kept", bus_rdata, 32'h0003_00FF);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule